// File: doc/BRIEF.md
# Serial NOR Flash Word Reader on a Wishbone Slave Port

This block lets a processor or other bus master read 32-bit words straight out of an external serial NOR flash. A Wishbone read turns into one single-bit SPI transaction. The block sends the standard read opcode and a 24-bit byte address, then clocks in four data bytes. It packs those bytes into one word, raises the bus acknowledge and keeps the word on its read-data output.

The bus address counts words. A fixed base offset, 2 MiB by default, is added so that the bus sees a window of the flash that lies beyond the configuration image. Write cycles are acknowledged and otherwise dropped, so a stray store cannot hang the bus. The flash side runs in SPI mode 0, with the serial clock at half the system clock.

Top module: `sfr_flash_reader`

## Requirements
- R1: After reset, the flash select pin is high (deselected), the serial clock is low, acknowledge is low and the read-data output is zero.
- R2: A flash transaction starts only when the cycle and strobe inputs are both high. Strobe alone or cycle alone does not select the flash and does not acknowledge.
- R3: Each read transaction shifts out the opcode 0x03 and then a 24-bit address, all most significant bit first. The address is (OFFSET + 4 × bus address) modulo 2^24, with OFFSET defaulting to 0x200000.
- R4: Each read transaction produces exactly 64 rising serial clock edges: 32 for the command and address, then 32 for four data bytes read on the input line, each byte MSB first.
- R5: The serial clock is low whenever the flash is deselected. While the flash is selected, the clock changes level on every system clock, so it runs at half the system clock.
- R6: Once the word is ready, acknowledge rises and stays high for as long as strobe is held. It falls on the first clock edge after strobe goes low.
- R7: The read-data output changes only when a read transaction completes. Between reads it holds the last fetched word.
- R8: A write cycle (write enable high) is acknowledged without selecting the flash, and it leaves the read-data output unchanged.
- R9: The flash select is released for at least one system clock between two transactions.
- R10: The word is assembled little-endian. The byte at the lowest flash address goes to bits 7:0, and the byte at the highest goes to bits 31:24.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wb_cyc_i | input | 1 | Bus cycle in progress |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write enable; writes are acknowledged and dropped |
| wb_adr_i | input | ADR_W (22) | Word address within the flash window |
| wb_ack_o | output | 1 | Acknowledge, held until strobe falls |
| wb_dat_o | output | 32 | Last word fetched from flash |
| spi_cs_no | output | 1 | Flash select, active low |
| spi_sck_o | output | 1 | Serial clock, idles low |
| spi_mosi_o | output | 1 | Serial data to flash |
| spi_miso_i | input | 1 | Serial data from flash |

## Verification
The hardest cases to reach from the ports are the ones where the flash must not move: a write cycle, a strobe without a cycle, and a master that keeps strobe high long after the acknowledge. A bench that only checks returned words never probes these. The stimulus therefore interleaves these cases with real reads. The flash model counts select assertions and clock edges, so a write that secretly starts a transfer shows up as a changed count. An address near the top of the bus range makes the offset sum overflow 24 bits, which exercises the wrap of the flash address.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

   // bus-side controller states
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_BUSY = 2'd1,
      ST_ACK  = 2'd2
   } sfr_state_e;

   // standard single-bit read opcode for serial NOR flash
   localparam logic [7:0] SFR_READ_OP = 8'h03;

endpackage

// File: rtl/sfr_addr_map.sv
// Maps a word-granular bus address onto a flash byte address.
module sfr_addr_map #(
   parameter int          ADR_W      = 22,
   parameter int          FA_BITS    = 24,
   parameter int          WORD_BYTES = 4,
   parameter logic [31:0] OFFSET     = 32'h0020_0000
) (
   input  logic [ADR_W-1:0]   adr_i,
   output logic [FA_BITS-1:0] faddr_o
);

   localparam int SH    = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 0;
   localparam int SUM_W = ((ADR_W + SH + 1) > 33) ? (ADR_W + SH + 1) : 33;
   localparam bit POW2  = ((1 << SH) == WORD_BYTES);

   logic [SUM_W-1:0] scaled;
   logic [SUM_W-1:0] total;

   generate
      if (POW2) begin : g_shift
         assign scaled = SUM_W'(adr_i) << SH;
      end else begin : g_mult
         assign scaled = SUM_W'(adr_i) * SUM_W'(WORD_BYTES);
      end
   endgenerate

   assign total   = scaled + SUM_W'(OFFSET);
   assign faddr_o = total[FA_BITS-1:0];

   always_comb begin
      assert (WORD_BYTES >= 1)
         else $error("sfr_addr_map: WORD_BYTES must be positive");
   end

endmodule

// File: rtl/sfr_word_pack.sv
// Reorders received bytes into the bus word.
module sfr_word_pack #(
   parameter int WORD_BYTES = 4,
   parameter bit LSB_FIRST  = 1'b1
) (
   input  logic [8*WORD_BYTES-1:0] rx_i,
   output logic [8*WORD_BYTES-1:0] word_o
);

   generate
      for (genvar k = 0; k < WORD_BYTES; k++) begin : g_byte
         // k-th received byte sits at the top of the shift register when k = 0
         if (LSB_FIRST) begin : g_le
            assign word_o[8*k +: 8] = rx_i[8*(WORD_BYTES-1-k) +: 8];
         end else begin : g_be
            assign word_o[8*k +: 8] = rx_i[8*k +: 8];
         end
      end
   endgenerate

endmodule

// File: rtl/sfr_spi_engine.sv
// Mode 0 serial engine: shifts a frame out, then shifts a word in.
module sfr_spi_engine #(
   parameter int TX_BITS = 32,
   parameter int RX_BITS = 32
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               start_i,
   input  logic [TX_BITS-1:0] frame_i,
   input  logic               miso_i,
   output logic               sel_o,
   output logic               sck_o,
   output logic               mosi_o,
   output logic               done_o,
   output logic [RX_BITS-1:0] rx_o
);

   localparam int TOTAL = TX_BITS + RX_BITS;
   localparam int CW    = $clog2(TOTAL + 1);

   logic               sel_q;
   logic               sck_q;
   logic               done_q;
   logic [TX_BITS-1:0] tx_q;
   logic [RX_BITS-1:0] rx_q;
   logic [CW-1:0]      cnt_q;

   generate
      if (TX_BITS < 2 || RX_BITS < 2) begin : g_bad_len
         $error("sfr_spi_engine: frame lengths must be at least 2 bits");
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sel_q  <= 1'b0;
         sck_q  <= 1'b0;
         done_q <= 1'b0;
         tx_q   <= '0;
         rx_q   <= '0;
         cnt_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (!sel_q) begin
            sck_q <= 1'b0;
            if (start_i) begin
               sel_q <= 1'b1;
               tx_q  <= frame_i;
               cnt_q <= CW'(TOTAL);
            end
         end else if (!sck_q) begin
            // rising edge of the serial clock
            sck_q <= 1'b1;
         end else begin
            // falling edge: input bit has been stable since the last fall
            sck_q <= 1'b0;
            tx_q  <= {tx_q[TX_BITS-2:0], 1'b0};
            if (cnt_q <= CW'(RX_BITS)) begin
               rx_q <= {rx_q[RX_BITS-2:0], miso_i};
            end
            cnt_q <= cnt_q - CW'(1);
            if (cnt_q == CW'(1)) begin
               sel_q  <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign sel_o  = sel_q;
   assign sck_o  = sck_q;
   assign mosi_o = tx_q[TX_BITS-1];
   assign done_o = done_q;
   assign rx_o   = rx_q;

   assert_sck_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sel_q |-> !sck_q);

   assert_sck_toggle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_q && sck_q) |=> !sck_q);

   assert_cs_gap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(sel_q) |=> !sel_q);

   assert_done_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q |-> !sel_q);

endmodule

// File: rtl/sfr_flash_reader.sv
// Wishbone read-only window onto a serial NOR flash.
module sfr_flash_reader
   import sfr_pkg::*;
#(
   parameter int          ADR_W      = 22,
   parameter int          ADDR_BYTES = 3,
   parameter int          WORD_BYTES = 4,
   parameter logic [31:0] OFFSET     = 32'h0020_0000,
   parameter bit          LSB_FIRST  = 1'b1,
   parameter logic [7:0]  READ_OP    = SFR_READ_OP
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    wb_cyc_i,
   input  logic                    wb_stb_i,
   input  logic                    wb_we_i,
   input  logic [ADR_W-1:0]        wb_adr_i,
   output logic                    wb_ack_o,
   output logic [8*WORD_BYTES-1:0] wb_dat_o,
   output logic                    spi_cs_no,
   output logic                    spi_sck_o,
   output logic                    spi_mosi_o,
   input  logic                    spi_miso_i
);

   localparam int FA_BITS = 8 * ADDR_BYTES;
   localparam int TX_BITS = 8 + FA_BITS;
   localparam int DW      = 8 * WORD_BYTES;

   generate
      if (ADDR_BYTES != 3 && ADDR_BYTES != 4) begin : g_bad_addr
         $error("sfr_flash_reader: ADDR_BYTES must be 3 or 4");
      end
      if (WORD_BYTES < 1 || WORD_BYTES > 8) begin : g_bad_word
         $error("sfr_flash_reader: WORD_BYTES out of range");
      end
      if (ADR_W < 1) begin : g_bad_adr
         $error("sfr_flash_reader: ADR_W must be positive");
      end
   endgenerate

   sfr_state_e         state_q;
   logic               ack_q;
   logic [DW-1:0]      dat_q;
   logic               req;
   logic               start;
   logic [FA_BITS-1:0] faddr;
   logic [TX_BITS-1:0] frame;
   logic               eng_sel;
   logic               eng_done;
   logic [DW-1:0]      eng_rx;
   logic [DW-1:0]      packed_word;

   assign req   = wb_cyc_i && wb_stb_i;
   assign start = (state_q == ST_IDLE) && req && !wb_we_i;
   assign frame = {READ_OP, faddr};

   sfr_addr_map #(
      .ADR_W      (ADR_W),
      .FA_BITS    (FA_BITS),
      .WORD_BYTES (WORD_BYTES),
      .OFFSET     (OFFSET)
   ) i_addr_map (
      .adr_i   (wb_adr_i),
      .faddr_o (faddr)
   );

   sfr_spi_engine #(
      .TX_BITS (TX_BITS),
      .RX_BITS (DW)
   ) i_engine (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start),
      .frame_i (frame),
      .miso_i  (spi_miso_i),
      .sel_o   (eng_sel),
      .sck_o   (spi_sck_o),
      .mosi_o  (spi_mosi_o),
      .done_o  (eng_done),
      .rx_o    (eng_rx)
   );

   sfr_word_pack #(
      .WORD_BYTES (WORD_BYTES),
      .LSB_FIRST  (LSB_FIRST)
   ) i_pack (
      .rx_i   (eng_rx),
      .word_o (packed_word)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         ack_q   <= 1'b0;
         dat_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (req) begin
                  if (wb_we_i) begin
                     ack_q   <= 1'b1;
                     state_q <= ST_ACK;
                  end else begin
                     state_q <= ST_BUSY;
                  end
               end
            end
            ST_BUSY: begin
               if (eng_done) begin
                  dat_q   <= packed_word;
                  ack_q   <= 1'b1;
                  state_q <= ST_ACK;
               end
            end
            ST_ACK: begin
               if (!wb_stb_i) begin
                  ack_q   <= 1'b0;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // active-high select inside, active-low at the pin
   assign spi_cs_no = !eng_sel;
   assign wb_ack_o  = ack_q;
   assign wb_dat_o  = dat_q;

   assert_start_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(eng_sel) |-> $past(wb_cyc_i && wb_stb_i && !wb_we_i));

   assert_ack_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_q && wb_stb_i) |=> ack_q);

   assert_ack_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_q && !wb_stb_i) |=> !ack_q);

   assert_data_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !eng_done |=> $stable(dat_q));

   assert_write_no_flash_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_IDLE && req && wb_we_i) |=> (!eng_sel && ack_q));

   assert_no_sel_in_ack_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_ACK) |-> !eng_sel);

endmodule

// File: tb/test_sfr_flash_reader.sv
module test_sfr_flash_reader;

   localparam int CLK_PERIOD = 10;
   localparam int ADR_W      = 22;
   localparam logic [23:0] OFS = 24'h20_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
   logic [ADR_W-1:0] adr = '0;
   logic        ack;
   logic [31:0] dat;
   logic        cs_n, sck, mosi;
   logic        miso = 1'b0;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sfr_flash_reader i_sfr_flash_reader (
      .clk_i(clk), .rst_ni(rst_n),
      .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we), .wb_adr_i(adr),
      .wb_ack_o(ack), .wb_dat_o(dat),
      .spi_cs_no(cs_n), .spi_sck_o(sck), .spi_mosi_o(mosi), .spi_miso_i(miso)
   );

   function automatic logic [7:0] fbyte(input logic [23:0] a);
      return a[7:0] ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'h3C;
   endfunction

   function automatic logic [23:0] faddr_of(input logic [ADR_W-1:0] w);
      logic [31:0] s;
      s = 32'(OFS) + (32'(w) << 2);
      return s[23:0];
   endfunction

   function automatic logic [31:0] word_of(input logic [ADR_W-1:0] w);
      logic [23:0] a;
      a = faddr_of(w);
      return {fbyte(a + 24'd3), fbyte(a + 24'd2), fbyte(a + 24'd1), fbyte(a)};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // ---------------- flash model ----------------
   int          nbit = 0;
   int          ntxn = 0;
   int          last_nbit = 0;
   logic [31:0] hdr = '0;
   logic [7:0]  got_cmd = '0;
   logic [23:0] got_addr = '0;

   always @(negedge cs_n) begin
      nbit = 0;
      ntxn++;
   end
   always @(posedge cs_n) last_nbit = nbit;
   always @(posedge sck) if (!cs_n) begin
      if (nbit < 32) hdr = {hdr[30:0], mosi};
      nbit++;
      if (nbit == 32) begin
         got_cmd  = hdr[31:24];
         got_addr = hdr[23:0];
      end
   end
   always @(negedge sck) if (!cs_n && nbit >= 32) begin
      int idx;
      logic [7:0] b;
      idx  = nbit - 32;
      b    = fbyte(got_addr + 24'(idx / 8));
      miso = b[7 - (idx % 8)];
   end

   // ---------------- line monitor (R5, R9) ----------------
   int   sck_bad = 0;
   int   gap_bad = 0;
   logic prev_sck = 1'b0, prev_cs = 1'b1;
   always @(negedge clk) if (rst_n) begin
      if (cs_n && sck) sck_bad++;
      if (!cs_n && !prev_cs && (sck == prev_sck)) sck_bad++;
      if (!cs_n && !prev_cs && ack) gap_bad++;
      prev_sck = sck;
      prev_cs  = cs_n;
   end

   // ---------------- scoreboard ----------------
   logic [31:0] exp_q[$];
   logic [31:0] last_exp = '0;
   logic        ack_prev = 1'b0;

   always @(negedge clk) begin
      if (rst_n && ack && !ack_prev) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R7 unexpected ack", 32'(ack), 32'h0);
         end else begin
            logic [31:0] e;
            e = exp_q.pop_front();
            chk(dat === e, "R10/R7 word", dat, e);
         end
      end
      ack_prev = ack;
   end

   task automatic wb_read(input logic [ADR_W-1:0] w, input int hold);
      int t0;
      last_exp = word_of(w);
      exp_q.push_back(last_exp);
      t0 = ntxn;
      @(negedge clk);
      cyc = 1'b1; stb = 1'b1; we = 1'b0; adr = w;
      @(negedge clk);
      while (!ack) @(negedge clk);
      for (int i = 0; i < hold; i++) begin
         @(negedge clk);
         chk(ack === 1'b1, "R6 ack held", 32'(ack), 32'h1);
      end
      cyc = 1'b0; stb = 1'b0;
      @(negedge clk);
      chk(ack === 1'b0, "R6 ack drop", 32'(ack), 32'h0);
      chk(got_cmd === 8'h03, "R3 opcode", 32'(got_cmd), 32'h03);
      chk(got_addr === faddr_of(w), "R3 address", 32'(got_addr), 32'(faddr_of(w)));
      chk(last_nbit == 64, "R4 clock count", 32'(last_nbit), 32'd64);
      chk(ntxn == t0 + 1, "R4 one transaction", 32'(ntxn), 32'(t0 + 1));
   endtask

   task automatic wb_write(input logic [ADR_W-1:0] w);
      int t0;
      exp_q.push_back(last_exp);
      t0 = ntxn;
      @(negedge clk);
      cyc = 1'b1; stb = 1'b1; we = 1'b1; adr = w;
      @(negedge clk);
      while (!ack) @(negedge clk);
      cyc = 1'b0; stb = 1'b0; we = 1'b0;
      @(negedge clk);
      chk(ack === 1'b0, "R6 write ack drop", 32'(ack), 32'h0);
      chk(ntxn == t0, "R8 no flash traffic", 32'(ntxn), 32'(t0));
      chk(dat === last_exp, "R8 data unchanged", dat, last_exp);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(cs_n === 1'b1, "R1 cs", 32'(cs_n), 32'h1);
      chk(sck === 1'b0, "R1 sck", 32'(sck), 32'h0);
      chk(ack === 1'b0, "R1 ack", 32'(ack), 32'h0);
      chk(dat === 32'h0, "R1 data", dat, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: strobe without cycle, cycle without strobe
      begin
         int bad = 0;
         stb = 1'b1;
         repeat (8) begin @(negedge clk); if (!cs_n || ack) bad++; end
         stb = 1'b0; cyc = 1'b1;
         repeat (8) begin @(negedge clk); if (!cs_n || ack) bad++; end
         cyc = 1'b0;
         chk(bad == 0 && ntxn == 0, "R2 gating", 32'(bad), 32'h0);
      end

      wb_read('0, 0);                      // R3 R4 R10 base of window
      wb_read(22'd5, 4);                   // R6 long strobe
      wb_write(22'd7);                     // R8
      begin                                // R7: hold between reads
         repeat (20) @(negedge clk);
         chk(dat === last_exp, "R7 hold", dat, last_exp);
      end
      wb_read(22'h12345, 0);
      wb_read(22'h12346, 1);               // R9 back to back
      wb_read({ADR_W{1'b1}}, 0);           // R3 address wrap
      wb_write(22'h0);                     // R8 after wrap
      wb_read(22'd1, 2);

      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R7 all acks seen", 32'(exp_q.size()), 32'h0);
      chk(sck_bad == 0, "R5 clock shape", 32'(sck_bad), 32'h0);
      chk(gap_bad == 0, "R9 select gap", 32'(gap_bad), 32'h0);
      finish_run();
   end

endmodule